// File: doc/BRIEF.md
# Row-Banked 3x3 Median Filter

This block removes isolated defects, such as a dead pixel or a failed line one pixel wide, from an image that arrives one row at a time. Each incoming row is written pixel by pixel into a rolling store of three rows. When a row is committed, the oldest stored row is dropped. Once three rows are held, the block replaces every interior pixel of the middle row with the median of the nine pixels in the 3x3 window centred on it.

The work is split across a bank of identical median units. Their centre columns lie three apart, so no two units read the same window. The bank visits the row in three phases and moves every unit one column to the right between phases, so the middle row is covered in exactly three phases. Each median leaves on a result port as a valid pulse with its column index and value. The block drops its ready output while a pass runs. The producer waits for ready before writing the next row.

Top module: `median3x3_rowbank`

## Requirements
- R1: A synchronous active-high reset empties the row store, clears the count of committed rows and idles the sequencer. After reset `ready` is 1 and `outValid` is 0.
- R2: While `ready` is 1, a cycle with `wrEn` high and `wrCol` < N stores `wrData` as pixel `wrCol` (0-based) of the row being assembled.
- R3: A `rowDone` pulse while `ready` is 1 commits the assembled row as the newest stored row and discards the oldest one.
- R4: The first two committed rows after reset produce no result. Every later commit starts exactly one pass over the row committed just before it. `ready` only falls in the cycle after a `rowDone`.
- R5: Each result value is the fifth smallest of the nine unsigned pixels in the 3x3 window centred on (middle row, `outCol`). With ties, any value equal to that rank is correct.
- R6: Results are produced only for the 0-based centre columns 1 to N-2. Columns 0 and N-1 never appear on `outCol`.
- R7: A pass runs phase 0, then phase 1, then phase 2. Phase p emits centre columns 1+p, 4+p, 7+p and so on up to N-2, in ascending order. Every interior column appears exactly once per pass.
- R8: `ready` is 0 from the cycle after a triggering commit until the pass ends. Writes and `rowDone` pulses during that time have no effect on any result.
- R9: At most one result is emitted per clock cycle. Consecutive results inside one phase are three columns apart.
- R10: A reset during a pass abandons it: no further result of that pass appears, and three new rows are needed before the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Pixel write strobe |
| wrCol | input | COL_W | 0-based column of the written pixel |
| wrData | input | PIX_W | Pixel value |
| rowDone | input | 1 | Commits the assembled row |
| ready | output | 1 | High when rows may be written and committed |
| outValid | output | 1 | Result strobe |
| outCol | output | COL_W | 0-based centre column of the result |
| outMedian | output | PIX_W | Median of the window |

## Verification
Several internal faults would each show up at the ports within one pass of the next commit:
- A rotation pointer that slips would frame windows from the wrong rows, so medians go wrong over textured or defective rows.
- A phase or unit counter fault would break the column order, or skip or repeat a column.
- A busy flag that lets writes through would corrupt the oldest row while it is still inside the windows.

The scoreboard compares every result in order against an independent rank-count model. Leftover or unexpected results are reported as soon as the run drains or the result appears.

// File: rtl/medfilt_pkg.sv
package medfilt_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic       wrStrobe;   // store a pixel into the assembling row
    logic       rotate;     // commit assembling row as newest
    logic       emit;       // selected unit result is valid this cycle
    logic [1:0] phase;      // phase 0..2 of the current pass
    logic [7:0] unitSel;    // unit whose result is emitted
  } seqCtrl_t;

  // units needed so that centre columns 1..n-2 are covered in three phases
  function automatic int unitCount(input int n);
    return n / 3;
  endfunction

  function automatic logic [1:0] nextSlot(input logic [1:0] s);
    return (s == 2'd2) ? 2'd0 : s + 2'd1;
  endfunction

endpackage

// File: rtl/median9_unit.sv
module median9_unit #(
  parameter int PIX_W = 8
) (
  input  logic [9*PIX_W-1:0] window,
  output logic [PIX_W-1:0]   median
);
  logic [PIX_W-1:0] lane [9];
  logic [PIX_W-1:0] swapTmp;

  // odd-even transposition network, nine rounds fully order nine values
  always_comb begin
    swapTmp = '0;
    for (int i = 0; i < 9; i++) lane[i] = window[i*PIX_W +: PIX_W];
    for (int rnd = 0; rnd < 9; rnd++) begin
      for (int i = 0; i < 8; i++) begin
        if (((i % 2) == (rnd % 2)) && (lane[i] > lane[i+1])) begin
          swapTmp   = lane[i];
          lane[i]   = lane[i+1];
          lane[i+1] = swapTmp;
        end
      end
    end
    median = lane[4];
  end
endmodule

// File: rtl/medfilt_datapath.sv
module medfilt_datapath
  import medfilt_pkg::*;
#(
  parameter int N     = 16,
  parameter int PIX_W = 8,
  parameter int UNITS = 5,
  parameter int COL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  seqCtrl_t         ctrlBus,
  input  logic [COL_W-1:0] wrCol,
  input  logic [PIX_W-1:0] wrData,
  output logic             outValid,
  output logic [COL_W-1:0] outCol,
  output logic [PIX_W-1:0] outMedian
);
  localparam int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1;

  logic [PIX_W-1:0] rowMem [3][N];
  logic [1:0]       headSlot;           // slot of the oldest row / assembling row
  logic [1:0]       midSlot, newSlot;
  logic [PIX_W-1:0] unitMed [UNITS];

  assign midSlot = nextSlot(headSlot);
  assign newSlot = nextSlot(midSlot);

  genvar k;
  generate
    for (k = 0; k < UNITS; k++) begin : g_unit
      logic [COL_W-1:0]   centre;
      logic [9*PIX_W-1:0] win;
      always_comb begin
        int c;
        c = 1 + 3*k + int'(ctrlBus.phase);
        if (c > N-2) c = N-2;
        centre = COL_W'(c);
        win = {rowMem[headSlot][centre-1], rowMem[headSlot][centre], rowMem[headSlot][centre+1],
               rowMem[midSlot][centre-1],  rowMem[midSlot][centre],  rowMem[midSlot][centre+1],
               rowMem[newSlot][centre-1],  rowMem[newSlot][centre],  rowMem[newSlot][centre+1]};
      end
      median9_unit #(.PIX_W(PIX_W)) u_med (.window(win), .median(unitMed[k]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      headSlot  <= 2'd0;
      outValid  <= 1'b0;
      outCol    <= '0;
      outMedian <= '0;
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < N; c++) rowMem[r][c] <= '0;
    end else begin
      if (ctrlBus.wrStrobe) rowMem[headSlot][wrCol] <= wrData;
      if (ctrlBus.rotate)   headSlot <= midSlot;
      outValid <= ctrlBus.emit;
      if (ctrlBus.emit) begin
        outCol    <= COL_W'(1 + 3*int'(ctrlBus.unitSel) + int'(ctrlBus.phase));
        outMedian <= unitMed[ctrlBus.unitSel[UNIT_W-1:0]];
      end
    end
  end
endmodule

// File: rtl/medfilt_ctrl.sv
module medfilt_ctrl
  import medfilt_pkg::*;
#(
  parameter int N     = 16,
  parameter int UNITS = 5,
  parameter int COL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [COL_W-1:0] wrCol,
  input  logic             rowDone,
  output logic             ready,
  output seqCtrl_t         ctrlBus
);
  localparam int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1;

  typedef enum logic {ST_IDLE, ST_RUN} seqState_t;

  seqState_t         state;
  logic [1:0]        loadedCnt;
  logic [1:0]        phaseCnt;
  logic [UNIT_W-1:0] unitCnt;
  logic              lastSlot;

  assign ready = (state == ST_IDLE);
  assign lastSlot = (unitCnt == UNIT_W'(UNITS-1));

  always_comb begin
    int centre;
    centre = 1 + 3*int'(unitCnt) + int'(phaseCnt);
    ctrlBus.wrStrobe = ready && wrEn && (int'(wrCol) < N);
    ctrlBus.rotate   = ready && rowDone;
    ctrlBus.emit     = (state == ST_RUN) && (centre <= N-2);
    ctrlBus.phase    = phaseCnt;
    ctrlBus.unitSel  = 8'(unitCnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      loadedCnt <= 2'd0;
      phaseCnt  <= 2'd0;
      unitCnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (ctrlBus.rotate) begin
          if (loadedCnt != 2'd3) loadedCnt <= loadedCnt + 2'd1;
          if (loadedCnt >= 2'd2) begin
            state    <= ST_RUN;
            phaseCnt <= 2'd0;
            unitCnt  <= '0;
          end
        end
        ST_RUN: begin
          if (lastSlot) begin
            unitCnt <= '0;
            if (phaseCnt == 2'd2) state <= ST_IDLE;
            else phaseCnt <= phaseCnt + 2'd1;
          end else begin
            unitCnt <= unitCnt + UNIT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/median3x3_rowbank.sv
module median3x3_rowbank
  import medfilt_pkg::*;
#(
  parameter int N     = 16,
  parameter int PIX_W = 8,
  parameter int COL_W = $clog2(N+1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [COL_W-1:0] wrCol,
  input  logic [PIX_W-1:0] wrData,
  input  logic             rowDone,
  output logic             ready,
  output logic             outValid,
  output logic [COL_W-1:0] outCol,
  output logic [PIX_W-1:0] outMedian
);
  localparam int UNITS = unitCount(N);

  seqCtrl_t ctrlBus;

  medfilt_ctrl #(.N(N), .UNITS(UNITS), .COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrCol(wrCol), .rowDone(rowDone),
    .ready(ready), .ctrlBus(ctrlBus)
  );

  medfilt_datapath #(.N(N), .PIX_W(PIX_W), .UNITS(UNITS), .COL_W(COL_W)) u_dp (
    .clk(clk), .rst(rst), .ctrlBus(ctrlBus), .wrCol(wrCol), .wrData(wrData),
    .outValid(outValid), .outCol(outCol), .outMedian(outMedian)
  );
endmodule

// File: rtl/median3x3_rowbank_chk.sv
module median3x3_rowbank_chk #(
  parameter int N     = 16,
  parameter int COL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             ready,
  input logic             rowDone,
  input logic             outValid,
  input logic [COL_W-1:0] outCol
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (ready && !outValid));

  assert_interior_only_R6: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (int'(outCol) >= 1 && int'(outCol) <= N-2));

  assert_busy_when_emitting_R8: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !$past(ready));

  assert_start_on_commit_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(rowDone));

  assert_phase_stride_R9: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(outValid)) |->
      ((int'(outCol) == int'($past(outCol)) + 3) || (outCol < $past(outCol))));
endmodule

bind median3x3_rowbank median3x3_rowbank_chk #(.N(N), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .rowDone(rowDone),
  .outValid(outValid), .outCol(outCol)
);

// File: tb/tb_median3x3_rowbank.sv
module tb_median3x3_rowbank;
  localparam int N     = 16;
  localparam int PIX_W = 8;
  localparam int COL_W = $clog2(N+1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [COL_W-1:0] wrCol = '0;
  logic [PIX_W-1:0] wrData = '0;
  logic rowDone = 1'b0;
  logic ready, outValid;
  logic [COL_W-1:0] outCol;
  logic [PIX_W-1:0] outMedian;

  int checks = 0;
  int errors = 0;
  int expCol[$];
  int expMed[$];
  int mdl[3][N];      // [0] oldest, [1] middle, [2] newest
  int loaded = 0;
  int curRow[N];
  int seed = 7;

  median3x3_rowbank #(.N(N), .PIX_W(PIX_W)) dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrCol(wrCol), .wrData(wrData),
    .rowDone(rowDone), .ready(ready), .outValid(outValid),
    .outCol(outCol), .outMedian(outMedian)
  );

  always #5 clk = ~clk;

  function automatic int rankMedian(input int v[9]);
    for (int i = 0; i < 9; i++) begin
      int lt = 0, le = 0;
      for (int j = 0; j < 9; j++) begin
        if (v[j] < v[i]) lt++;
        if (v[j] <= v[i]) le++;
      end
      if (lt <= 4 && le >= 5) return v[i];
    end
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pushPass();
    for (int p = 0; p < 3; p++)
      for (int c = 1 + p; c <= N-2; c += 3) begin
        int w[9];
        for (int r = 0; r < 3; r++)
          for (int d = 0; d < 3; d++) w[r*3+d] = mdl[r][c-1+d];
        expCol.push_back(c);
        expMed.push_back(rankMedian(w));
      end
  endtask

  // drives one row; optionally hammers the ports while the pass runs (R8)
  task automatic loadRow(input bit noisy);
    bit trig;
    while (!ready) begin @(posedge clk); #1; end
    for (int c = 0; c < N; c++) begin
      wrEn = 1'b1; wrCol = COL_W'(c); wrData = PIX_W'(curRow[c]);
      @(posedge clk); #1;
    end
    wrEn = 1'b0; rowDone = 1'b1;
    mdl[0] = mdl[1]; mdl[1] = mdl[2];
    for (int c = 0; c < N; c++) mdl[2][c] = curRow[c];
    if (loaded < 3) loaded++;
    trig = (loaded == 3);
    if (trig) pushPass();
    @(posedge clk); #1;
    rowDone = 1'b0;
    if (trig) check(ready == 1'b0, "R8 ready low in pass", int'(ready), 0);
    else      check(ready == 1'b1, "R4 no pass before three rows", int'(ready), 1);
    if (noisy && trig) begin
      for (int i = 0; i < 6; i++) begin
        wrEn = 1'b1; wrCol = COL_W'(i + 3); wrData = 8'hFF; rowDone = 1'b1;
        @(posedge clk); #1;
      end
      wrEn = 1'b0; rowDone = 1'b0;
    end
  endtask

  function automatic int nextRand();
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return (seed >> 8) & 255;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expCol.size() == 0) begin
        check(1'b0, "R4 unexpected result", int'(outCol), -1);
      end else begin
        int ec, em;
        ec = expCol.pop_front();
        em = expMed.pop_front();
        check(int'(outCol) == ec, "R7 column order", int'(outCol), ec);
        check(int'(outMedian) == em, "R5 median value", int'(outMedian), em);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic drain();
    repeat (40) @(posedge clk);
    #1;
    check(expCol.size() == 0, "R7 every column emitted", expCol.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);

    // R2 R3 R4: two rows, no results
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < N; c++) curRow[c] = c * 10 + r;
      loadRow(1'b0);
    end
    repeat (20) @(posedge clk);
    #1;
    check(outValid == 1'b0, "R4 silent with two rows", int'(outValid), 0);

    // R5 R6 textured rows, rolling store R3
    for (int r = 0; r < 5; r++) begin
      for (int c = 0; c < N; c++) curRow[c] = nextRand();
      loadRow(1'b0);
    end
    // impulse defect
    for (int c = 0; c < N; c++) curRow[c] = 100;
    curRow[6] = 255;
    loadRow(1'b0);
    for (int c = 0; c < N; c++) curRow[c] = 100 + c;
    loadRow(1'b0);
    // dead column across rows
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < N; c++) curRow[c] = 50 + r;
      curRow[9] = 0;
      loadRow(1'b0);
    end
    // ties and extremes
    for (int c = 0; c < N; c++) curRow[c] = 77;
    loadRow(1'b0);
    for (int c = 0; c < N; c++) curRow[c] = (c % 2) ? 255 : 0;
    loadRow(1'b0);
    drain();

    // R8: writes and commits during a pass are ignored
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < N; c++) curRow[c] = nextRand();
      loadRow(1'b1);
    end
    drain();

    // R10: reset mid-pass
    for (int c = 0; c < N; c++) curRow[c] = nextRand();
    loadRow(1'b0);
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b1;
    expCol.delete();
    expMed.delete();
    loaded = 0;
    @(posedge clk); #1;
    rst = 1'b0;
    check(ready == 1'b1, "R10 ready after abort", int'(ready), 1);
    check(outValid == 1'b0, "R10 no result after abort", int'(outValid), 0);
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < N; c++) curRow[c] = (r * 40 + c * 13) % 256;
      loadRow(1'b0);
    end
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule